// File: doc/BRIEF.md
# Register Rename Undo Log

This block keeps an ordered record of every destination-register rename made by a single-thread rename stage, so that the machine can return to a precise state. Each record carries the sequence number of the instruction that renamed, the architectural register it wrote, the physical register it was newly given and the physical register that held that architectural register before. Records are kept oldest to youngest in a circular buffer.

The log drains from two ends. When instructions retire, the commit port frees records from the oldest end and hands back their previous physical registers to the free list, a bounded number per cycle. When a misprediction or exception flushes younger work, the squash port starts a walk from the youngest end. The walk undoes one record per cycle, driving the architectural register and its earlier physical register onto the restore output for the rename map, until no record younger than the squash sequence number remains. Separate running totals count freed mappings and undone mappings.

Sequence numbers are assumed to grow monotonically, without wrap, over the lifetime of any record in the log. DEPTH must be a power of two and COMMIT_W must not exceed DEPTH.

Top module: `rename_undo_log`

## Requirements
- R1: After reset, full, busy, restore_valid and every free_valid bit are 0, and both running totals are 0.
- R2: An allocation is recorded when alloc_valid is high, full is low, squash_valid is low and busy is low. The record's previous physical register later appears on free_preg when it commits, and its architectural register and both physical registers appear on the restore outputs when it is undone.
- R3: full is 1 exactly while DEPTH records are held. An allocation presented while full is refused and leaves the log unchanged.
- R4: In each cycle with commit_valid high, records are freed from the oldest end in order, up to COMMIT_W of them. In the next cycle, free_valid bit i and free_preg bits [i*PREG_W +: PREG_W] carry the i-th freed record, where slot 0 is the oldest. The set bits of free_valid are always the lowest ones.
- R5: A record whose sequence number is greater than commit_seq is not freed. Freeing stops at the first such record, even when later slots would be free.
- R6: busy is 1 in the cycle after squash_valid. In each following cycle the youngest record with a sequence number greater than the squash number is removed. In the next cycle it appears on restore_valid, restore_areg, restore_preg (its previous physical register) and restore_new_preg. Records are removed youngest first.
- R7: busy falls in the cycle after the one where no record younger than the squash number remains. Records at or below the squash number stay in the log.
- R8: An allocation presented in a cycle with squash_valid high, or while busy is 1, is dropped.
- R9: commit_cnt increases by the number of records freed, and undo_cnt by the number undone. Both update in the same cycle as free_valid and restore_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Rename presents a destination rename |
| alloc_seq | input | SEQ_W | Sequence number of the renaming instruction |
| alloc_areg | input | AREG_W | Architectural destination register |
| alloc_new_preg | input | PREG_W | Physical register newly assigned |
| alloc_old_preg | input | PREG_W | Physical register mapped before the rename |
| full | output | 1 | Log holds DEPTH records |
| commit_valid | input | 1 | Free records up to commit_seq this cycle |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Start an undo walk |
| squash_seq | input | SEQ_W | Records above this number are undone |
| busy | output | 1 | Undo walk in progress |
| restore_valid | output | 1 | Restore outputs carry an undone record |
| restore_areg | output | AREG_W | Architectural register to restore |
| restore_preg | output | PREG_W | Mapping to write back for restore_areg |
| restore_new_preg | output | PREG_W | Physical register the undone rename had taken |
| free_valid | output | COMMIT_W | Per-slot valid for released registers |
| free_preg | output | COMMIT_W*PREG_W | Released previous physical registers, slot 0 oldest |
| commit_cnt | output | CTR_W | Running total of freed mappings |
| undo_cnt | output | CTR_W | Running total of undone mappings |

## Verification
The bench builds the log with DEPTH 4, COMMIT_W 2 and a 6-bit sequence number. At that size, every commit threshold and every squash threshold between below-oldest and above-youngest can be applied to a full log: 11 values each, covering zero, partial and complete drains. It also covers the case where the per-cycle commit limit cuts a drain short and the case where an allocation is tried against a full log. Every undo walk is run with allocations held high, which shows that they are dropped.

// File: rtl/rul_pkg.sv
// Shared types for the rename undo log.
package rul_pkg;
    // State of the squash walker: idle or undoing from the youngest end.
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_UNDO = 1'b1
    } walk_e;
endpackage

// File: rtl/rul_store.sv
// Record storage of the undo log.
// Holds DEPTH records in plain registers. One write port at the tail, COMMIT_W
// read ports at consecutive slots from the head, and one read port at the
// youngest record. Assumes DEPTH is a power of two, so pointers wrap naturally.
module rul_store #(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 8,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int COMMIT_W = 2,
    localparam int PTR_W   = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             wr_en,
    input  logic [PTR_W-1:0]                 wr_ptr,
    input  logic [SEQ_W-1:0]                 wr_seq,
    input  logic [AREG_W-1:0]                wr_areg,
    input  logic [PREG_W-1:0]                wr_new,
    input  logic [PREG_W-1:0]                wr_old,
    input  logic [PTR_W-1:0]                 hd_ptr,
    output logic [COMMIT_W-1:0][SEQ_W-1:0]   hd_seq,
    output logic [COMMIT_W-1:0][PREG_W-1:0]  hd_old,
    input  logic [PTR_W-1:0]                 yg_ptr,
    output logic [SEQ_W-1:0]                 yg_seq,
    output logic [AREG_W-1:0]                yg_areg,
    output logic [PREG_W-1:0]                yg_new,
    output logic [PREG_W-1:0]                yg_old
);
    logic [SEQ_W-1:0]  seq_m  [DEPTH];
    logic [AREG_W-1:0] areg_m [DEPTH];
    logic [PREG_W-1:0] new_m  [DEPTH];
    logic [PREG_W-1:0] old_m  [DEPTH];

    // Write one record at the tail slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            seq_m[wr_ptr]  <= wr_seq;
            areg_m[wr_ptr] <= wr_areg;
            new_m[wr_ptr]  <= wr_new;
            old_m[wr_ptr]  <= wr_old;
        end
    end

    // Read ports for the oldest COMMIT_W slots.
    for (genvar i = 0; i < COMMIT_W; i++) begin : g_hd
        logic [PTR_W-1:0] idx;
        assign idx       = hd_ptr + PTR_W'(i);
        assign hd_seq[i] = seq_m[idx];
        assign hd_old[i] = old_m[idx];
    end

    assign yg_seq  = seq_m[yg_ptr];
    assign yg_areg = areg_m[yg_ptr];
    assign yg_new  = new_m[yg_ptr];
    assign yg_old  = old_m[yg_ptr];
endmodule

// File: rtl/rul_commit_scan.sv
// Commit selector: decides which of the oldest COMMIT_W records retire.
// A slot is taken when it holds a record, its sequence number is at or below
// the limit, and every older slot is taken too. Assumes avail never exceeds
// the log occupancy.
module rul_commit_scan #(
    parameter int COMMIT_W = 2,
    parameter int SEQ_W    = 8,
    parameter int CNT_W    = 4,
    localparam int NF_W    = $clog2(COMMIT_W + 1)
) (
    input  logic                           en,
    input  logic [CNT_W-1:0]               avail,
    input  logic [SEQ_W-1:0]               limit,
    input  logic [COMMIT_W-1:0][SEQ_W-1:0] slot_seq,
    output logic [COMMIT_W-1:0]            take,
    output logic [NF_W-1:0]                n_take
);
    // Chain of slot qualifiers, each gated by its older neighbour.
    for (genvar i = 0; i < COMMIT_W; i++) begin : g_take
        logic ok;
        assign ok = (CNT_W'(i) < avail) && (slot_seq[i] <= limit);
        if (i == 0) begin : g_first
            assign take[i] = en && ok;
        end else begin : g_rest
            assign take[i] = take[i-1] && ok;
        end
    end

    // Number of slots taken this cycle.
    always_comb begin
        n_take = '0;
        for (int i = 0; i < COMMIT_W; i++) n_take = n_take + NF_W'(take[i]);
    end
endmodule

// File: rtl/rename_undo_log.sv
// Rename undo log, single thread.
// Keeps destination renames in allocation order. Commit frees from the oldest
// end, and a squash walks back from the youngest end one record per cycle.
// Assumes monotonic sequence numbers, DEPTH a power of two, COMMIT_W <= DEPTH.
module rename_undo_log #(
    parameter int DEPTH    = 16,
    parameter int SEQ_W    = 8,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int COMMIT_W = 2,
    parameter int CTR_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [SEQ_W-1:0]             alloc_seq,
    input  logic [AREG_W-1:0]            alloc_areg,
    input  logic [PREG_W-1:0]            alloc_new_preg,
    input  logic [PREG_W-1:0]            alloc_old_preg,
    output logic                         full,
    input  logic                         commit_valid,
    input  logic [SEQ_W-1:0]             commit_seq,
    input  logic                         squash_valid,
    input  logic [SEQ_W-1:0]             squash_seq,
    output logic                         busy,
    output logic                         restore_valid,
    output logic [AREG_W-1:0]            restore_areg,
    output logic [PREG_W-1:0]            restore_preg,
    output logic [PREG_W-1:0]            restore_new_preg,
    output logic [COMMIT_W-1:0]          free_valid,
    output logic [COMMIT_W*PREG_W-1:0]   free_preg,
    output logic [CTR_W-1:0]             commit_cnt,
    output logic [CTR_W-1:0]             undo_cnt
);
    import rul_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int NF_W  = $clog2(COMMIT_W + 1);

    logic [PTR_W-1:0] head_q, tail_q, yg_ptr;
    logic [CNT_W-1:0] cnt_q, avail;
    walk_e            walk_q;
    logic [SEQ_W-1:0] sq_seq_q;

    logic [COMMIT_W-1:0][SEQ_W-1:0]  hd_seq;
    logic [COMMIT_W-1:0][PREG_W-1:0] hd_old;
    logic [SEQ_W-1:0]  yg_seq;
    logic [AREG_W-1:0] yg_areg;
    logic [PREG_W-1:0] yg_new, yg_old;
    logic [COMMIT_W-1:0] take;
    logic [NF_W-1:0]     n_take;
    logic alloc_go, undo_go;

    // Derive the per-cycle actions from state and requests.
    always_comb begin
        yg_ptr   = tail_q - PTR_W'(1);
        full     = (cnt_q == CNT_W'(DEPTH));
        busy     = (walk_q == WALK_UNDO);
        undo_go  = busy && (cnt_q != '0) && (yg_seq > sq_seq_q);
        avail    = cnt_q - CNT_W'(undo_go);
        alloc_go = alloc_valid && !full && !squash_valid && !busy;
    end

    rul_store #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
        .PREG_W(PREG_W), .COMMIT_W(COMMIT_W)
    ) u_store (
        .clk(clk), .wr_en(alloc_go), .wr_ptr(tail_q),
        .wr_seq(alloc_seq), .wr_areg(alloc_areg),
        .wr_new(alloc_new_preg), .wr_old(alloc_old_preg),
        .hd_ptr(head_q), .hd_seq(hd_seq), .hd_old(hd_old),
        .yg_ptr(yg_ptr), .yg_seq(yg_seq), .yg_areg(yg_areg),
        .yg_new(yg_new), .yg_old(yg_old)
    );

    rul_commit_scan #(
        .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
    ) u_scan (
        .en(commit_valid), .avail(avail), .limit(commit_seq),
        .slot_seq(hd_seq), .take(take), .n_take(n_take)
    );

    // Pointers, occupancy and the walker state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q   <= '0;
            tail_q   <= '0;
            cnt_q    <= '0;
            walk_q   <= WALK_IDLE;
            sq_seq_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(n_take);
            tail_q <= tail_q + PTR_W'(alloc_go) - PTR_W'(undo_go);
            cnt_q  <= cnt_q + CNT_W'(alloc_go) - CNT_W'(undo_go) - CNT_W'(n_take);
            if (squash_valid) begin
                walk_q   <= WALK_UNDO;
                sq_seq_q <= squash_seq;
            end else if (busy && !undo_go) begin
                walk_q <= WALK_IDLE;
            end
        end
    end

    // Registered outputs towards the rename map, the free list and the totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restore_valid    <= 1'b0;
            restore_areg     <= '0;
            restore_preg     <= '0;
            restore_new_preg <= '0;
            free_valid       <= '0;
            free_preg        <= '0;
            commit_cnt       <= '0;
            undo_cnt         <= '0;
        end else begin
            restore_valid <= undo_go;
            if (undo_go) begin
                restore_areg     <= yg_areg;
                restore_preg     <= yg_old;
                restore_new_preg <= yg_new;
            end
            free_valid <= take;
            free_preg  <= hd_old;
            commit_cnt <= commit_cnt + CTR_W'(n_take);
            undo_cnt   <= undo_cnt + CTR_W'(undo_go);
        end
    end
endmodule

// File: rtl/rul_checker.sv
// Property checker for the rename undo log, attached by bind.
// Watches occupancy, the walker and the drain outputs.
module rul_checker #(
    parameter int DEPTH    = 16,
    parameter int COMMIT_W = 2,
    parameter int CTR_W    = 16,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                squash_valid,
    input logic                full,
    input logic                busy,
    input logic                restore_valid,
    input logic [COMMIT_W-1:0] free_valid,
    input logic [CNT_W-1:0]    cnt,
    input logic [CTR_W-1:0]    commit_cnt,
    input logic [CTR_W-1:0]    undo_cnt
);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> cnt <= $past(cnt));

    p_drop_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid || busy) |=> cnt <= $past(cnt));

    p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> busy);

    p_restore_in_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> $past(busy));

    p_undo_tally_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> undo_cnt == $past(undo_cnt) + CTR_W'(1));

    p_commit_tally_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_cnt == $past(commit_cnt) + CTR_W'($countones(free_valid)));

    for (genvar i = 1; i < COMMIT_W; i++) begin : g_pack
        p_free_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
            free_valid[i] |-> free_valid[i-1]);
    end
endmodule

bind rename_undo_log rul_checker #(
    .DEPTH(DEPTH), .COMMIT_W(COMMIT_W), .CTR_W(CTR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .squash_valid(squash_valid),
    .full(full), .busy(busy), .restore_valid(restore_valid),
    .free_valid(free_valid), .cnt(cnt_q),
    .commit_cnt(commit_cnt), .undo_cnt(undo_cnt)
);

// File: tb/sim_rename_undo_log.sv
`timescale 1ns/1ps
// Bench for the rename undo log: sweeps commit and squash thresholds over a
// full four-entry log and checks against a queue model built from the brief.
module sim_rename_undo_log;
    localparam int DEPTH = 4, SEQ_W = 6, AREG_W = 4, PREG_W = 6, CW = 2, CTR_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 1'b0, commit_valid = 1'b0, squash_valid = 1'b0;
    logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
    logic [AREG_W-1:0] alloc_areg = '0;
    logic [PREG_W-1:0] alloc_new_preg = '0, alloc_old_preg = '0;
    logic full, busy, restore_valid;
    logic [AREG_W-1:0] restore_areg;
    logic [PREG_W-1:0] restore_preg, restore_new_preg;
    logic [CW-1:0] free_valid;
    logic [CW*PREG_W-1:0] free_preg;
    logic [CTR_W-1:0] commit_cnt, undo_cnt;

    rename_undo_log #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
        .PREG_W(PREG_W), .COMMIT_W(CW), .CTR_W(CTR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .alloc_areg(alloc_areg), .alloc_new_preg(alloc_new_preg),
        .alloc_old_preg(alloc_old_preg), .full(full), .commit_valid(commit_valid),
        .commit_seq(commit_seq), .squash_valid(squash_valid), .squash_seq(squash_seq),
        .busy(busy), .restore_valid(restore_valid), .restore_areg(restore_areg),
        .restore_preg(restore_preg), .restore_new_preg(restore_new_preg),
        .free_valid(free_valid), .free_preg(free_preg),
        .commit_cnt(commit_cnt), .undo_cnt(undo_cnt));

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, exp_commit = 0, exp_undo = 0;
    int q_seq[$], q_areg[$], q_new[$], q_old[$];

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Offer one allocation (R2, R3); the model keeps it only if not full.
    task automatic do_alloc(int s, int a, int nw, int od);
        bit acc = (q_seq.size() < DEPTH);
        alloc_valid = 1'b1; alloc_seq = SEQ_W'(s); alloc_areg = AREG_W'(a);
        alloc_new_preg = PREG_W'(nw); alloc_old_preg = PREG_W'(od);
        @(negedge clk);
        alloc_valid = 1'b0;
        if (acc) begin
            q_seq.push_back(s); q_areg.push_back(a); q_new.push_back(nw); q_old.push_back(od);
        end
    endtask

    // Seed four records with sequence numbers 10,12,14,16.
    task automatic fill4(int v);
        for (int k = 0; k < 4; k++) do_alloc(10 + 2*k, (v + k) % 16, (v*4 + k + 20) % 64, (v*4 + k) % 64);
        chk("R3", "full after four allocations", int'(full), 1);
    endtask

    // One commit cycle, checked slot by slot (R4, R5, R9).
    task automatic commit_cycle(int cs);
        bit go = 1'b1;
        commit_valid = 1'b1; commit_seq = SEQ_W'(cs);
        @(negedge clk);
        commit_valid = 1'b0;
        for (int i = 0; i < CW; i++) begin
            go = go && (q_seq.size() > 0) && (q_seq[0] <= cs);
            chk(go ? "R4" : "R5", "free_valid slot", int'(free_valid[i]), int'(go));
            if (go) begin
                chk("R4", "free_preg slot", int'(free_preg[i*PREG_W +: PREG_W]), q_old[0]);
                void'(q_seq.pop_front()); void'(q_areg.pop_front());
                void'(q_new.pop_front()); void'(q_old.pop_front());
                exp_commit++;
            end
        end
        chk("R9", "commit_cnt", int'(commit_cnt), exp_commit);
    endtask

    task automatic drain();
        while (q_seq.size() > 0) commit_cycle(63);
        chk("R3", "full after drain", int'(full), 0);
    endtask

    // Squash walk with allocations held high throughout (R6, R7, R8, R9).
    task automatic squash_walk(int ss);
        squash_valid = 1'b1; squash_seq = SEQ_W'(ss);
        alloc_valid = 1'b1; alloc_seq = 6'd62; alloc_areg = 4'd15;
        alloc_new_preg = 6'd63; alloc_old_preg = 6'd61;
        @(negedge clk);
        squash_valid = 1'b0;
        chk("R6", "busy after squash", int'(busy), 1);
        chk("R6", "no restore yet", int'(restore_valid), 0);
        while (q_seq.size() > 0 && q_seq[$] > ss) begin
            @(negedge clk);
            chk("R6", "restore_valid", int'(restore_valid), 1);
            chk("R6", "restore_areg", int'(restore_areg), q_areg[$]);
            chk("R6", "restore_preg", int'(restore_preg), q_old[$]);
            chk("R6", "restore_new_preg", int'(restore_new_preg), q_new[$]);
            void'(q_seq.pop_back()); void'(q_areg.pop_back());
            void'(q_new.pop_back()); void'(q_old.pop_back());
            exp_undo++;
        end
        @(negedge clk);
        alloc_valid = 1'b0;
        chk("R7", "busy falls", int'(busy), 0);
        chk("R7", "restore idle", int'(restore_valid), 0);
        chk("R9", "undo_cnt", int'(undo_cnt), exp_undo);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "full", int'(full), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "restore_valid", int'(restore_valid), 0);
        chk("R1", "free_valid", int'(free_valid), 0);
        chk("R1", "commit_cnt", int'(commit_cnt), 0);
        chk("R1", "undo_cnt", int'(undo_cnt), 0);

        // R3: allocation refused while full; drain shows only four records.
        fill4(0);
        do_alloc(20, 9, 9, 9);
        chk("R3", "model occupancy", q_seq.size(), 4);
        drain();

        // R8, R7: squash on an empty log finishes after one busy cycle.
        squash_walk(5);
        drain();

        // R4, R5: every commit threshold against a full log.
        for (int cs = 8; cs <= 18; cs++) begin
            fill4(cs);
            commit_cycle(cs);
            drain();
        end

        // R6, R7, R8: every squash threshold against a full log.
        for (int ss = 8; ss <= 18; ss++) begin
            fill4(ss + 3);
            squash_walk(ss);
            drain();
        end

        // Mixed: partial commit, then squash over the rest, then refill.
        fill4(7);
        commit_cycle(11);
        squash_walk(13);
        do_alloc(30, 3, 33, 44);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule